// File: doc/BRIEF.md
# Super I/O configuration port controller

This block is the configuration front end of a PC-style multi-function I/O device. A host talks to it over an 8-bit I/O bus that has a single address bit: address 0 (the even port) is the index port and address 1 (the odd port) is the data port. Write and read strobes qualify each access. The block holds a file of 42 byte-wide configuration registers, each with a fixed power-on value. Downstream address decoders and peripheral enables use these values, so the whole file is driven out as one flat bus.

Access is guarded by a key sequence. Two back-to-back writes of 0x55 to the index port open configuration mode, and a write of 0xAA to the index port closes it. While the mode is open, the host writes a register number to the index port and then reads or writes that register through the data port. Three registers cannot be written. A lock bit in register 1 makes the lower 24 registers read-only and hides their contents on reads. Once set, the lock stays set until reset.

The bus is a plain register-access port with no flow control. Every access finishes in the cycle of its strobe and no back-pressure exists. A write acts on the rising clock edge. Read data is combinational.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset, configuration mode is closed, the index is 0, the lock is clear, and the registers hold these values: 0x00=0x28, 0x01=0x9C, 0x02=0x88, 0x03=0x78, 0x06=0xFF, 0x0D=0x03, 0x0E=0x02, 0x1E=0x80, 0x26=0x23, 0x27=0x67, 0x28=0x43. Every other register holds 0x00.
- R2: While configuration mode is closed, configuration mode opens after two consecutive index-port writes of 0x55. An index-port write of any other value between the two clears the count. Data-port writes do not affect the count.
- R3: An index-port write of 0xAA while configuration mode is open closes it. The `cfg_mode` output is low from the next cycle.
- R4: In configuration mode, an index-port write of a value below 42 selects that register. A value of 42 or more leaves the index unchanged.
- R5: While configuration mode is closed, a strobed read returns 0xFF on either port and data-port writes change no register.
- R6: In configuration mode, a read of the index port (`addr_sel`=0) returns the selected register number, zero-extended. A read of the data port (`addr_sel`=1) returns the selected register.
- R7: Data-port writes to registers 0x26, 0x27 and 0x29 are ignored.
- R8: An accepted data write to register 1 sets the lock when bit 3 of the written value is 0, and clears it when bit 3 is 1. While the lock is set, registers 0x00 to 0x17 ignore writes and read back as 0xFF. Register 1 is in that range, so only reset clears the lock.
- R9: An accepted data-port write updates the selected register on the clock edge where `wr_en` is high. `regs_flat[8*i+7:8*i]` always shows register i, whether or not the lock is set.
- R10: When `rd_en` is low, `rdata` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_sel | input | 1 | 0 selects the index port, 1 selects the data port |
| wr_en | input | 1 | Write strobe, one access per cycle |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| cfg_mode | output | 1 | High while configuration mode is open |
| regs_flat | output | 336 | All 42 registers, register i at bits 8*i+7 to 8*i |

## Verification
A wrong internal state has visible effects at the ports:
- A wrong key counter makes `cfg_mode` rise one key write early or late.
- A wrong index changes the zero-extended number read back from the index port.
- A wrong lock flag turns data-port reads of the lower registers into 0xFF, or lets a protected byte change on `regs_flat`.

Each of these shows at the ports within one clock of the access that caused it. The bench compares `cfg_mode`, `rdata` and every byte of `regs_flat` against a behavioural model on every cycle, so the first wrong cycle is reported.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
  localparam int CFG_NUM_REGS   = 42;
  localparam int CFG_DW         = 8;
  localparam int CFG_LOCK_REG   = 1;
  localparam int CFG_LOCK_BIT   = 3;
  localparam int CFG_LOCK_LIMIT = 24;
  localparam logic [7:0] KEY_OPEN  = 8'h55;
  localparam logic [7:0] KEY_CLOSE = 8'hAA;

  // Power-on value of register i.
  function automatic logic [7:0] rst_val(input int i);
    case (i)
      0:       return 8'h28;
      1:       return 8'h9C;
      2:       return 8'h88;
      3:       return 8'h78;
      6:       return 8'hFF;
      13:      return 8'h03;
      14:      return 8'h02;
      30:      return 8'h80;
      38:      return 8'h23;
      39:      return 8'h67;
      40:      return 8'h43;
      default: return 8'h00;
    endcase
  endfunction

  // Registers that never accept data writes.
  function automatic logic is_ro(input int i);
    return (i == 38) || (i == 39) || (i == 41);
  endfunction
endpackage

// File: rtl/sio_cfg_entry.sv
module sio_cfg_entry
  import sio_cfg_pkg::*;
#(
  parameter int NUM_REGS = CFG_NUM_REGS,
  parameter int DW       = CFG_DW,
  localparam int IW      = $clog2(NUM_REGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          idx_wr,
  input  logic [DW-1:0] wdata,
  output logic          cfg_mode,
  output logic [IW-1:0] idx
);
  localparam logic [DW-1:0] NREG_B = DW'(NUM_REGS);

  logic key_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_mode <= 1'b0;
      key_seen <= 1'b0;
      idx      <= '0;
    end else if (idx_wr) begin
      if (!cfg_mode) begin
        if (wdata == DW'(KEY_OPEN)) begin
          cfg_mode <= key_seen;
          key_seen <= ~key_seen;
        end else begin
          key_seen <= 1'b0;
        end
      end else begin
        if (wdata < NREG_B) idx <= wdata[IW-1:0];
        if (wdata == DW'(KEY_CLOSE)) cfg_mode <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sio_cfg_regs.sv
module sio_cfg_regs
  import sio_cfg_pkg::*;
#(
  parameter int NUM_REGS   = CFG_NUM_REGS,
  parameter int DW         = CFG_DW,
  parameter int LOCK_REG   = CFG_LOCK_REG,
  parameter int LOCK_BIT   = CFG_LOCK_BIT,
  parameter int LOCK_LIMIT = CFG_LOCK_LIMIT,
  localparam int IW        = $clog2(NUM_REGS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               data_wr,
  input  logic [IW-1:0]      idx,
  input  logic [DW-1:0]      wdata,
  output logic               lock,
  output logic [NUM_REGS*DW-1:0] regs_flat
);
  localparam logic [IW-1:0] LIM_I  = IW'(LOCK_LIMIT);
  localparam logic [IW-1:0] LOCK_I = IW'(LOCK_REG);

  logic wr_ok;
  assign wr_ok = data_wr && !is_ro(int'(idx)) && !(lock && (idx < LIM_I));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      lock <= 1'b0;
    else if (wr_ok && idx == LOCK_I) lock <= ~wdata[LOCK_BIT];
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [DW-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        q <= DW'(rst_val(i));
      else if (wr_ok && idx == IW'(i))   q <= wdata;
    end
    assign regs_flat[i*DW +: DW] = q;
  end
endmodule

// File: rtl/sio_cfg_rdmux.sv
module sio_cfg_rdmux
  import sio_cfg_pkg::*;
#(
  parameter int NUM_REGS   = CFG_NUM_REGS,
  parameter int DW         = CFG_DW,
  parameter int LOCK_LIMIT = CFG_LOCK_LIMIT,
  localparam int IW        = $clog2(NUM_REGS)
) (
  input  logic                   rd_en,
  input  logic                   addr_sel,
  input  logic                   cfg_mode,
  input  logic                   lock,
  input  logic [IW-1:0]          idx,
  input  logic [NUM_REGS*DW-1:0] regs_flat,
  output logic [DW-1:0]          rdata
);
  localparam logic [IW-1:0] LIM_I = IW'(LOCK_LIMIT);

  always_comb begin
    if (!rd_en)                    rdata = '0;
    else if (!cfg_mode)            rdata = '1;
    else if (!addr_sel)            rdata = {{(DW-IW){1'b0}}, idx};
    else if (lock && idx < LIM_I)  rdata = '1;
    else                           rdata = regs_flat[idx*DW +: DW];
  end
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter int NUM_REGS   = CFG_NUM_REGS,
  parameter int DW         = CFG_DW,
  parameter int LOCK_REG   = CFG_LOCK_REG,
  parameter int LOCK_BIT   = CFG_LOCK_BIT,
  parameter int LOCK_LIMIT = CFG_LOCK_LIMIT
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   addr_sel,
  input  logic                   wr_en,
  input  logic                   rd_en,
  input  logic [DW-1:0]          wdata,
  output logic [DW-1:0]          rdata,
  output logic                   cfg_mode,
  output logic [NUM_REGS*DW-1:0] regs_flat
);
  localparam int IW = $clog2(NUM_REGS);

  logic [IW-1:0] idx;
  logic          lock;

  sio_cfg_entry #(.NUM_REGS(NUM_REGS), .DW(DW)) u_entry (
    .clk(clk), .rst_n(rst_n), .idx_wr(wr_en && !addr_sel),
    .wdata(wdata), .cfg_mode(cfg_mode), .idx(idx)
  );

  sio_cfg_regs #(
    .NUM_REGS(NUM_REGS), .DW(DW), .LOCK_REG(LOCK_REG),
    .LOCK_BIT(LOCK_BIT), .LOCK_LIMIT(LOCK_LIMIT)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .data_wr(wr_en && addr_sel && cfg_mode),
    .idx(idx), .wdata(wdata), .lock(lock), .regs_flat(regs_flat)
  );

  sio_cfg_rdmux #(.NUM_REGS(NUM_REGS), .DW(DW), .LOCK_LIMIT(LOCK_LIMIT)) u_rd (
    .rd_en(rd_en), .addr_sel(addr_sel), .cfg_mode(cfg_mode), .lock(lock),
    .idx(idx), .regs_flat(regs_flat), .rdata(rdata)
  );
endmodule

// File: rtl/sio_cfg_port_chk.sv
module sio_cfg_port_chk #(
  parameter int NUM_REGS = 42,
  parameter int DW       = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   addr_sel,
  input logic                   wr_en,
  input logic                   rd_en,
  input logic [DW-1:0]          wdata,
  input logic [DW-1:0]          rdata,
  input logic                   cfg_mode,
  input logic [NUM_REGS*DW-1:0] regs_flat
);
  localparam logic [DW-1:0] NREG_B = DW'(NUM_REGS);

  AST_CLOSED_READ_FF: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !cfg_mode) |-> rdata == '1); // R5

  AST_CLOSED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_mode |=> $stable(regs_flat)); // R5

  AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rdata == '0); // R10

  AST_CLOSE_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode && wr_en && !addr_sel && wdata == 8'hAA) |=> !cfg_mode); // R3

  AST_OPEN_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_mode && !(wr_en && !addr_sel && wdata == 8'h55)) |=> !cfg_mode); // R2

  AST_INDEX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && cfg_mode && !addr_sel) |-> rdata < NREG_B); // R4

  AST_RO_26_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(regs_flat[38*DW +: DW])); // R7

  AST_RO_29_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(regs_flat[41*DW +: DW])); // R7
endmodule

bind sio_cfg_port sio_cfg_port_chk #(.NUM_REGS(NUM_REGS), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel), .wr_en(wr_en),
  .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .cfg_mode(cfg_mode),
  .regs_flat(regs_flat)
);

// File: tb/sim_sio_cfg_port.sv
`timescale 1ns/1ps
module sim_sio_cfg_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        addr_sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  wdata = 8'h00;
  logic [7:0]  rdata;
  logic        cfg_mode;
  logic [335:0] regs_flat;

  int total = 0, bad = 0;
  bit done = 1'b0;

  // behavioural reference state
  int m_reg[42];
  bit m_mode, m_seen, m_lock, m_live;
  int m_idx;

  always #2.5 clk = ~clk;

  sio_cfg_port u0 (
    .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel), .wr_en(wr_en),
    .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .cfg_mode(cfg_mode),
    .regs_flat(regs_flat)
  );

  function automatic int init_val(int i);
    case (i)
      0: return 'h28;  1: return 'h9C;  2: return 'h88;  3: return 'h78;
      6: return 'hFF; 13: return 'h03; 14: return 'h02; 30: return 'h80;
      38: return 'h23; 39: return 'h67; 40: return 'h43;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 42; i++) m_reg[i] = init_val(i);
      m_mode = 0; m_seen = 0; m_lock = 0; m_idx = 0; m_live = 1;
    end else if (wr_en) begin
      if (!addr_sel) begin
        if (!m_mode) begin
          if (wdata == 8'h55) begin
            if (m_seen) begin m_mode = 1; m_seen = 0; end else m_seen = 1;
          end else m_seen = 0;
        end else begin
          if (int'(wdata) < 42) m_idx = int'(wdata);
          if (wdata == 8'hAA) m_mode = 0;
        end
      end else if (m_mode) begin
        if (m_idx != 38 && m_idx != 39 && m_idx != 41 && !(m_lock && m_idx < 24)) begin
          m_reg[m_idx] = int'(wdata);
          if (m_idx == 1) m_lock = !wdata[3];
        end
      end
    end
  end

  function automatic logic [7:0] exp_rdata();
    if (!rd_en) return 8'h00;
    if (!m_mode) return 8'hFF;
    if (!addr_sel) return 8'(m_idx);
    if (m_lock && m_idx < 24) return 8'hFF;
    return 8'(m_reg[m_idx]);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && m_live && !done) begin
      chk("R3 cfg_mode vs model", int'(cfg_mode), int'(m_mode));
      chk("R6 rdata vs model", int'(rdata), int'(exp_rdata()));
      for (int i = 0; i < 42; i++)
        if (int'(regs_flat[i*8 +: 8]) != m_reg[i])
          chk($sformatf("R9 regs_flat byte %0d", i), int'(regs_flat[i*8 +: 8]), m_reg[i]);
      total++;
    end
  end

  task automatic idx_wr(input logic [7:0] v);
    @(posedge clk); #1; addr_sel = 0; wdata = v; wr_en = 1;
    @(posedge clk); #1; wr_en = 0;
  endtask

  task automatic dat_wr(input logic [7:0] v);
    @(posedge clk); #1; addr_sel = 1; wdata = v; wr_en = 1;
    @(posedge clk); #1; wr_en = 0;
  endtask

  task automatic rd(input logic sel, output logic [7:0] v);
    @(posedge clk); #1; addr_sel = sel; rd_en = 1;
    @(negedge clk); v = rdata;
    @(posedge clk); #1; rd_en = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; repeat (3) @(posedge clk); #1; rst_n = 1;
  endtask

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    do_reset();
    // R1 / R5 / R10 while closed
    chk("R1 cfg_mode after reset", int'(cfg_mode), 0);
    chk("R10 rdata idle", int'(rdata), 0);
    rd(0, v); chk("R5 closed index read", v, 'hFF);
    rd(1, v); chk("R5 closed data read", v, 'hFF);
    dat_wr(8'h12);
    chk("R5 closed data write ignored", int'(regs_flat[7:0]), 'h28);
    // R2 broken and good sequences
    idx_wr(8'h55); idx_wr(8'h12); idx_wr(8'h55);
    chk("R2 interrupted key", int'(cfg_mode), 0);
    dat_wr(8'h00); idx_wr(8'h55);
    chk("R2 second key opens", int'(cfg_mode), 1);
    // R6 / R1 reads
    rd(0, v); chk("R6 index read", v, 0);
    rd(1, v); chk("R1 reg0 default", v, 'h28);
    idx_wr(8'h28); rd(1, v); chk("R1 reg 0x28 default", v, 'h43);
    // R4 index range
    idx_wr(8'd50); rd(0, v); chk("R4 out-of-range index kept", v, 'h28);
    idx_wr(8'd41); rd(0, v); chk("R4 index 41 selected", v, 41);
    // R9 write
    idx_wr(8'h10); dat_wr(8'hA5); rd(1, v); chk("R9 write reg 0x10", v, 'hA5);
    chk("R9 flat byte 0x10", int'(regs_flat[16*8 +: 8]), 'hA5);
    // R7 read-only
    idx_wr(8'h26); dat_wr(8'h00); rd(1, v); chk("R7 reg 0x26 protected", v, 'h23);
    idx_wr(8'h27); dat_wr(8'h00); rd(1, v); chk("R7 reg 0x27 protected", v, 'h67);
    idx_wr(8'h29); dat_wr(8'h5C); rd(1, v); chk("R7 reg 0x29 protected", v, 0);
    // R8 lock
    idx_wr(8'h01); dat_wr(8'h94); rd(1, v); chk("R8 locked reg1 reads FF", v, 'hFF);
    chk("R9 flat shows reg1 under lock", int'(regs_flat[15:8]), 'h94);
    idx_wr(8'h10); dat_wr(8'h5A); rd(1, v); chk("R8 locked low read FF", v, 'hFF);
    chk("R8 locked low write ignored", int'(regs_flat[16*8 +: 8]), 'hA5);
    idx_wr(8'h18); dat_wr(8'h77); rd(1, v); chk("R8 upper bank writable", v, 'h77);
    idx_wr(8'h01); dat_wr(8'h9C); idx_wr(8'h02); rd(1, v);
    chk("R8 lock persists", v, 'hFF);
    // R3 close
    idx_wr(8'hAA); chk("R3 close key", int'(cfg_mode), 0);
    rd(1, v); chk("R3 closed read", v, 'hFF);
    // R1 reset again clears lock and contents
    do_reset();
    idx_wr(8'h55); idx_wr(8'h55); idx_wr(8'h10); rd(1, v);
    chk("R1 reset clears lock and reg 0x10", v, 0);
    idx_wr(8'h1E); rd(1, v); chk("R1 reg 0x1E default", v, 'h80);
    repeat (2) @(posedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule